// File: doc/BRIEF.md
# Triple Watchdog Timer Register Block

This block holds three independent watchdog timers behind a small register bus. Each timer is a 16-bit down-counter that moves one step per 0.1 s tick. A prescaler counter with a configurable divide ratio derives that tick from the system clock. Software starts a timer by writing its reload value. It keeps the timer alive by reading the counter register: the read returns the count and also reloads the counter. If software stops doing this, the count reaches zero and the timer performs its own expiry action.

The three actions differ:

- Timer 0 raises a level interrupt.
- Timer 1 pulses a processor-only reset.
- Timer 2 pulses a board-wide power-on reset.

A shared mask byte can suppress any of these actions. Masking does not stop the counter. Sixteen-bit values cross the bus with their two bytes swapped, because the registers keep the low byte first.

The bus is single-cycle. Read data is combinational from the current state plus the presented address. Side effects of an access take place at the clock edge that closes the access cycle.

Top module: `wdtrio_top`

## Requirements
- R1: While a timer is running, every tick lowers its count by one. A tick that finds the count at 1 or 0 leaves the count at 0, clears running and sets expired. When a timer is not running, ticks leave its count unchanged.
- R2: A read of a timer's counter register (offset +0x0) returns the current count. At the same edge it reloads the count from that timer's limit register. Running and expired do not change. A reload takes precedence over a tick in the same cycle.
- R3: A write to a timer's limit register (offset +0x4) has three effects:
  - It stores the value {wdata[7:0], wdata[15:8]} into both the limit and the count.
  - It sets running and clears expired.
  - It takes precedence over a tick in the same cycle.

  A read of the limit register has no side effect.
- R4: After reset, every timer's count and limit are 1, every status byte is 0, the mask is 0, and all three action outputs are low.
- R5: Timer i occupies the window at address 16*i, for i = 0, 1 or 2. Halfword reads return {reg[7:0], reg[15:8]}. The status register (offset +0x8) reads bit 0 = running and bit 1 = expired, with bits 15..2 zero. An access whose address bits [1:0] are not 00 has no effect and reads 0.
- R6: An unmasked expiry of timer 0 drives wdIrq high from the edge of expiry onwards. wdIrq stays high until the next write to timer 0's limit register, which clears it at that edge.
- R7: An unmasked expiry of timer 1 drives cpuRst high, and one of timer 2 drives boardRst high. Each pulse starts at the edge of expiry and lasts PULSE_W cycles.
- R8: The mask register at 0x30 uses bits 2..0 for timers 2..0; a 1 suppresses that timer's action. A masked timer still counts and still updates its status. The mask value that applies is the one held before an expiry edge. Reads of the mask return {13'b0, mask}.
- R9: The following read 0:
  - the auxiliary status register at 0x34;
  - every unmapped aligned address;
  - the read-data bus during a write cycle.

  Writes to read-only or unmapped addresses change nothing.
- R10: The prescaler produces one tick every DIV clock cycles, the first tick arriving DIV cycles after reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| busSel | input | 1 | Access strobe, one cycle per access |
| busWr | input | 1 | 1 = write, 0 = read |
| busAddr | input | 6 | Byte address of the access |
| busWdata | input | 16 | Write data (byte registers use bits 7..0) |
| busRdata | output | 16 | Read data for the current access |
| wdIrq | output | 1 | Timer 0 expiry interrupt, level |
| cpuRst | output | 1 | Timer 1 processor reset pulse |
| boardRst | output | 1 | Timer 2 board reset pulse |

## Verification
The hardest cases to reach are the collisions at one clock edge between a bus access and the tick. These are a reload read or a limit write landing on the very tick that would have expired the timer, and a mask write landing on an expiry edge. The bench uses a short divide ratio. It walks counter reads and limit writes across many cycle offsets relative to the tick, so each collision is hit more than once. A per-cycle behavioural model decides which side should win at each edge.

// File: rtl/wdtrio_pkg.sv
package wdtrio_pkg;
  localparam int NUM_TMR = 3;
  localparam int CNT_W   = 16;
  localparam int ADDR_W  = 6;

  // control-to-datapath strobes for one bus cycle
  typedef struct packed {
    logic [NUM_TMR-1:0] kick;    // counter read: reload from limit
    logic [NUM_TMR-1:0] load;    // limit write: store and start
    logic               maskWr;  // mask byte write
    logic [CNT_W-1:0]   wrVal;   // halfword after byte swap
    logic [7:0]         wrByte;  // byte lane for byte registers
  } strobe_t;
endpackage

// File: rtl/wdtrio_ctrl.sv
module wdtrio_ctrl
  import wdtrio_pkg::*;
(
  input  logic                busSel,
  input  logic                busWr,
  input  logic [ADDR_W-1:0]   busAddr,
  input  logic [15:0]         busWdata,
  input  logic [CNT_W-1:0]    cntArr [NUM_TMR],
  input  logic [CNT_W-1:0]    limArr [NUM_TMR],
  input  logic [NUM_TMR-1:0]  runVec,
  input  logic [NUM_TMR-1:0]  expVec,
  input  logic [NUM_TMR-1:0]  maskVal,
  output strobe_t             stb,
  output logic [15:0]         busRdata
);
  localparam logic [1:0] OFS_CNT  = 2'd0;
  localparam logic [1:0] OFS_LIM  = 2'd1;
  localparam logic [1:0] OFS_STAT = 2'd2;
  localparam logic [1:0] OFS_MASK = 2'd0;

  logic [1:0]  win;
  logic [1:0]  regSel;
  logic        hit;
  logic        rdHit;
  logic        wrHit;
  logic [15:0] rdVal;

  function automatic logic [15:0] swapHalf(input logic [15:0] v);
    return {v[7:0], v[15:8]};
  endfunction

  assign win    = busAddr[5:4];
  assign regSel = busAddr[3:2];
  assign hit    = busSel && (busAddr[1:0] == 2'b00);
  assign rdHit  = hit && !busWr;
  assign wrHit  = hit && busWr;

  always_comb begin
    stb        = '0;
    stb.wrVal  = swapHalf(busWdata);
    stb.wrByte = busWdata[7:0];
    rdVal      = '0;
    if (win == 2'd3) begin
      if (regSel == OFS_MASK) begin
        rdVal[NUM_TMR-1:0] = maskVal;
        stb.maskWr         = wrHit;
      end
    end else begin
      for (int i = 0; i < NUM_TMR; i++) begin
        if (win == 2'(i)) begin
          case (regSel)
            OFS_CNT: begin
              rdVal       = swapHalf(cntArr[i]);
              stb.kick[i] = rdHit;
            end
            OFS_LIM: begin
              rdVal       = swapHalf(limArr[i]);
              stb.load[i] = wrHit;
            end
            OFS_STAT: rdVal = {14'b0, expVec[i], runVec[i]};
            default:  rdVal = '0;
          endcase
        end
      end
    end
  end

  assign busRdata = rdHit ? rdVal : 16'h0000;
endmodule

// File: rtl/wdtrio_dpath.sv
module wdtrio_dpath
  import wdtrio_pkg::*;
#(
  parameter int DIV     = 20_000_000,
  parameter int PULSE_W = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  strobe_t            stb,
  output logic [CNT_W-1:0]   cntArr [NUM_TMR],
  output logic [CNT_W-1:0]   limArr [NUM_TMR],
  output logic [NUM_TMR-1:0] runVec,
  output logic [NUM_TMR-1:0] expVec,
  output logic [NUM_TMR-1:0] maskVal,
  output logic [NUM_TMR-1:0] actOut
);
  localparam int PRE_W = (DIV > 1) ? $clog2(DIV) : 1;
  localparam int PW_W  = $clog2(PULSE_W + 1);

  logic [PRE_W-1:0]   preCnt;
  logic               tick;
  logic [NUM_TMR-1:0] actFire;

  assign tick = (preCnt == PRE_W'(DIV - 1));

  always_ff @(posedge clk) begin
    if (!rstN)     preCnt <= '0;
    else if (tick) preCnt <= '0;
    else           preCnt <= preCnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN)           maskVal <= '0;
    else if (stb.maskWr) maskVal <= stb.wrByte[NUM_TMR-1:0];
  end

  for (genvar i = 0; i < NUM_TMR; i++) begin : g_tmr
    logic [CNT_W-1:0] cntQ;
    logic [CNT_W-1:0] limQ;
    logic             runQ;
    logic             expQ;
    logic             lastStep;

    assign lastStep   = (cntQ <= CNT_W'(1));
    assign actFire[i] = tick && runQ && lastStep && !stb.load[i]
                        && !stb.kick[i] && !maskVal[i];

    always_ff @(posedge clk) begin
      if (!rstN) begin
        cntQ <= CNT_W'(1);
        limQ <= CNT_W'(1);
        runQ <= 1'b0;
        expQ <= 1'b0;
      end else if (stb.load[i]) begin
        cntQ <= stb.wrVal;
        limQ <= stb.wrVal;
        runQ <= 1'b1;
        expQ <= 1'b0;
      end else if (stb.kick[i]) begin
        cntQ <= limQ;
      end else if (tick && runQ) begin
        if (lastStep) begin
          cntQ <= '0;
          runQ <= 1'b0;
          expQ <= 1'b1;
        end else begin
          cntQ <= cntQ - 1'b1;
        end
      end
    end

    assign cntArr[i] = cntQ;
    assign limArr[i] = limQ;
    assign runVec[i] = runQ;
    assign expVec[i] = expQ;

    if (i == 0) begin : g_irq
      logic irqQ;
      always_ff @(posedge clk) begin
        if (!rstN)            irqQ <= 1'b0;
        else if (stb.load[i]) irqQ <= 1'b0;
        else if (actFire[i])  irqQ <= 1'b1;
      end
      assign actOut[i] = irqQ;
    end else begin : g_pulse
      logic [PW_W-1:0] pulseCnt;
      always_ff @(posedge clk) begin
        if (!rstN)                pulseCnt <= '0;
        else if (actFire[i])      pulseCnt <= PW_W'(PULSE_W);
        else if (pulseCnt != '0)  pulseCnt <= pulseCnt - 1'b1;
      end
      assign actOut[i] = (pulseCnt != '0);
    end
  end
endmodule

// File: rtl/wdtrio_top.sv
module wdtrio_top
  import wdtrio_pkg::*;
#(
  parameter int DIV     = 20_000_000,
  parameter int PULSE_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [15:0]       busWdata,
  output logic [15:0]       busRdata,
  output logic              wdIrq,
  output logic              cpuRst,
  output logic              boardRst
);
  strobe_t            stb;
  logic [CNT_W-1:0]   cntArr [NUM_TMR];
  logic [CNT_W-1:0]   limArr [NUM_TMR];
  logic [NUM_TMR-1:0] runVec;
  logic [NUM_TMR-1:0] expVec;
  logic [NUM_TMR-1:0] maskVal;
  logic [NUM_TMR-1:0] actOut;

  wdtrio_ctrl ctrl_i (
    .busSel   (busSel),
    .busWr    (busWr),
    .busAddr  (busAddr),
    .busWdata (busWdata),
    .cntArr   (cntArr),
    .limArr   (limArr),
    .runVec   (runVec),
    .expVec   (expVec),
    .maskVal  (maskVal),
    .stb      (stb),
    .busRdata (busRdata)
  );

  wdtrio_dpath #(.DIV(DIV), .PULSE_W(PULSE_W)) dpath_i (
    .clk     (clk),
    .rstN    (rstN),
    .stb     (stb),
    .cntArr  (cntArr),
    .limArr  (limArr),
    .runVec  (runVec),
    .expVec  (expVec),
    .maskVal (maskVal),
    .actOut  (actOut)
  );

  assign wdIrq    = actOut[0];
  assign cpuRst   = actOut[1];
  assign boardRst = actOut[2];
endmodule

// File: rtl/wdtrio_chk.sv
module wdtrio_chk #(
  parameter int PULSE_W = 16
) (
  input logic        clk,
  input logic        rstN,
  input logic        busSel,
  input logic        busWr,
  input logic [5:0]  busAddr,
  input logic [15:0] busRdata,
  input logic        wdIrq,
  input logic        cpuRst,
  input logic        boardRst
);
  logic lim0Wr;
  int   cpuLen;
  int   brdLen;

  assign lim0Wr = busSel && busWr && (busAddr == 6'h04);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cpuLen <= 0;
      brdLen <= 0;
    end else begin
      cpuLen <= cpuRst   ? cpuLen + 1 : 0;
      brdLen <= boardRst ? brdLen + 1 : 0;
    end
  end

  AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (wdIrq && !lim0Wr) |=> wdIrq); // R6
  AST_IRQ_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    lim0Wr |=> !wdIrq); // R6
  AST_CPU_PULSE_WIDTH: assert property (@(posedge clk) disable iff (!rstN)
    $fell(cpuRst) |-> (cpuLen >= PULSE_W)); // R7
  AST_BOARD_PULSE_WIDTH: assert property (@(posedge clk) disable iff (!rstN)
    $fell(boardRst) |-> (brdLen >= PULSE_W)); // R7
  AST_STATUS_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && !busWr && busAddr[5:4] != 2'd3 && busAddr[3:0] == 4'h8)
      |-> (busRdata[15:2] == 14'd0)); // R5
  AST_AUX_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && !busWr && busAddr == 6'h34) |-> (busRdata == 16'd0)); // R9
  AST_WRITE_NO_RDATA: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && busWr) |-> (busRdata == 16'd0)); // R9
endmodule

bind wdtrio_top wdtrio_chk #(.PULSE_W(PULSE_W)) chk_i (
  .clk      (clk),
  .rstN     (rstN),
  .busSel   (busSel),
  .busWr    (busWr),
  .busAddr  (busAddr),
  .busRdata (busRdata),
  .wdIrq    (wdIrq),
  .cpuRst   (cpuRst),
  .boardRst (boardRst)
);

// File: tb/wdtrio_tb_top.sv
`timescale 1ns/100ps
module wdtrio_tb_top;
  localparam int DIV     = 4;
  localparam int PULSE_W = 3;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busSel = 1'b0;
  logic        busWr = 1'b0;
  logic [5:0]  busAddr = '0;
  logic [15:0] busWdata = '0;
  logic [15:0] busRdata;
  logic        wdIrq, cpuRst, boardRst;

  int total = 0;
  int bad   = 0;
  int cycles = 0;

  wdtrio_top #(.DIV(DIV), .PULSE_W(PULSE_W)) dut_i (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .wdIrq(wdIrq), .cpuRst(cpuRst), .boardRst(boardRst)
  );

  always #2.5 clk = ~clk;

  // behavioural reference state
  int mCnt [3];
  int mLim [3];
  bit mRun [3];
  bit mExp [3];
  int mPul [3];
  bit mIrq;
  int mMask;
  int mPre;

  function automatic int swp(input int v);
    return ((v & 255) << 8) | ((v >> 8) & 255);
  endfunction

  function automatic int modelRd();
    int t, off;
    if (!busSel || busWr || (busAddr % 4) != 0) return 0;
    t   = busAddr / 16;
    off = busAddr % 16;
    if (t < 3) begin
      if (off == 0) return swp(mCnt[t]);
      if (off == 4) return swp(mLim[t]);
      if (off == 8) return (int'(mExp[t]) << 1) | int'(mRun[t]);
      return 0;
    end
    if (off == 0) return mMask;
    return 0;
  endfunction

  function automatic string rdTag();
    int off;
    off = busAddr % 16;
    if (!busSel || busWr || (busAddr % 4) != 0) return "R9";
    if (busAddr / 16 == 3) return (off == 0) ? "R8" : "R9";
    if (off == 0) return "R1 R2 R10";
    if (off == 4) return "R3 R5";
    if (off == 8) return "R5";
    return "R9";
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < 3; i++) begin
        mCnt[i] = 1; mLim[i] = 1; mRun[i] = 0; mExp[i] = 0; mPul[i] = 0;
      end
      mIrq = 0; mMask = 0; mPre = 0;
    end else begin
      bit tk, rdA, wrA;
      int t, off;
      tk   = (mPre == DIV - 1);
      mPre = tk ? 0 : mPre + 1;
      rdA  = busSel && !busWr && (busAddr % 4) == 0;
      wrA  = busSel && busWr && (busAddr % 4) == 0;
      t    = busAddr / 16;
      off  = busAddr % 16;
      for (int i = 0; i < 3; i++) begin
        bit fire;
        fire = 0;
        if (mPul[i] > 0) mPul[i]--;
        if (wrA && t == i && off == 4) begin
          mCnt[i] = swp(busWdata); mLim[i] = mCnt[i];
          mRun[i] = 1; mExp[i] = 0;
          if (i == 0) mIrq = 0;
        end else if (rdA && t == i && off == 0) begin
          mCnt[i] = mLim[i];
        end else if (tk && mRun[i]) begin
          if (mCnt[i] <= 1) begin
            mCnt[i] = 0; mRun[i] = 0; mExp[i] = 1;
            fire = ((mMask >> i) & 1) == 0;
          end else mCnt[i]--;
        end
        if (fire) begin
          if (i == 0) mIrq = 1;
          else mPul[i] = PULSE_W;
        end
      end
      if (wrA && t == 3 && off == 0) mMask = busWdata & 7;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    if (!rstN) begin
      chk("R4 irq", int'(wdIrq), 0);
      chk("R4 cpuRst", int'(cpuRst), 0);
      chk("R4 boardRst", int'(boardRst), 0);
    end else begin
      chk(rdTag(), int'(busRdata), modelRd());
      chk("R6 irq", int'(wdIrq), int'(mIrq));
      chk("R7 cpuRst", int'(cpuRst), int'(mPul[1] != 0));
      chk("R7 boardRst", int'(boardRst), int'(mPul[2] != 0));
    end
  end

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(posedge clk); #1;
      busSel = 0; busWr = 0;
    end
  endtask

  task automatic acc(input bit w, input int a, input int d);
    @(posedge clk); #1;
    busSel = 1; busWr = w; busAddr = 6'(a); busWdata = 16'(d);
    @(posedge clk); #1;
    busSel = 0; busWr = 0;
  endtask

  task automatic readAll();
    for (int a = 0; a < 64; a += 4) acc(0, a, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1;
    // R4 R5: reset values through every register
    readAll();
    // R3 R6: start timer 0 with 5 (bus value byte swapped)
    acc(1, 6'h04, 16'h0500);
    acc(0, 6'h04, 0);
    idle(6);
    acc(0, 6'h00, 0);               // R2 kick
    idle(40);
    acc(0, 6'h08, 0);               // expired status
    acc(0, 6'h00, 0);               // kick stopped timer: reload only
    idle(10);
    acc(1, 6'h04, 16'h0200);        // R6 clear
    // R7: timers 1 and 2
    acc(1, 6'h14, 16'h0200);
    acc(1, 6'h24, 16'h0300);
    idle(30);
    // R8: mask timer 1, expiry produces no pulse
    acc(1, 6'h30, 16'h0002);
    acc(0, 6'h30, 0);
    acc(1, 6'h14, 16'h0300);
    for (int k = 0; k < 8; k++) begin acc(0, 6'h18, 0); idle(1); end
    idle(20);
    acc(1, 6'h30, 16'h0000);
    // R1 R2: kicks at every offset relative to the tick
    acc(1, 6'h24, 16'h0100);
    for (int k = 0; k < 12; k++) begin idle(k % 5); acc(0, 6'h20, 0); end
    idle(20);
    // R3 limit written at every offset, including zero
    for (int k = 0; k < 8; k++) begin
      idle(k % 4); acc(1, 6'h14, (k % 3) << 8);
    end
    idle(20);
    acc(1, 6'h04, 16'h3412);
    acc(0, 6'h04, 0);
    acc(0, 6'h00, 0);
    // R9: read-only and unmapped writes, misaligned accesses
    acc(1, 6'h08, 16'hFFFF);
    acc(1, 6'h34, 16'hFFFF);
    acc(1, 6'h3C, 16'hFFFF);
    acc(1, 6'h00, 16'h0100);
    acc(1, 6'h06, 16'h0100);
    acc(0, 6'h05, 0);
    acc(1, 6'h31, 16'h0007);
    readAll();
    // mask write colliding with expiry edges
    acc(1, 6'h14, 16'h0100);
    for (int k = 0; k < 6; k++) begin idle(k % 4); acc(1, 6'h30, (k % 2) * 7); end
    idle(30);
    readAll();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #100000;
    total++; bad++;
    $display("FAIL watchdog R1 actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule